// File: doc/BRIEF.md
# West-First Adaptive Output Port Selector

This block picks the output port for a packet at one hop of a two-dimensional mesh router. Each request carries the packet's remaining signed X and Y offsets to its destination. Alongside come three congestion flags, one each for the east, north and south neighbour links. The selector only ever picks a direction that shortens the remaining distance. It takes every westward hop before any other direction, so no packet ever turns into the west direction. Once the packet no longer needs to go west, it may choose between east and the needed vertical direction to steer around a busy link.

Requests enter on a valid/ready handshake. The chosen port leaves one cycle later on a second valid/ready handshake, through a single output register. When the consumer holds `sel_ready` low, the registered choice stays frozen. While that output register is full and stalled, `req_ready` is low, so a request is accepted only when the register is empty or is being drained in the same cycle. The congestion flags are sampled in the cycle the request is accepted.

Top module: `wf_route_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `sel_valid` is 0.
- R2: A request whose X offset is negative always selects WEST (code 2), whatever the congestion flags say.
- R3: When the X offset is not negative and only one direction is productive, that direction is chosen: EAST (code 1) when X>0 and Y=0, NORTH (code 3) when X=0 and Y>0, SOUTH (code 4) when X=0 and Y<0.
- R4: When both offsets are zero, LOCAL (code 0) is selected.
- R5: When X>0 and Y is non-zero, exactly one of the two productive links is congested, and the free one is chosen. Flag bit 0 marks east, bit 1 north, bit 2 south; a flag of 1 means congested.
- R6: When X>0 and Y is non-zero and the two productive links are both free or both congested, EAST is chosen.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both high) appears on `sel_valid`/`sel_port` right after that edge.
- R8: While `sel_valid` is high and `sel_ready` is low, `sel_port` and `sel_valid` hold their values and `req_ready` is low.
- R9: WEST is never selected for a request whose X offset is zero or positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_dx | input | OFF_W | Signed remaining X offset (positive = east) |
| req_dy | input | OFF_W | Signed remaining Y offset (positive = north) |
| link_busy | input | 3 | Congestion flags: bit 0 east, bit 1 north, bit 2 south |
| sel_valid | output | 1 | Selected port is held in the output register |
| sel_ready | input | 1 | Consumer takes the selection |
| sel_port | output | 3 | Chosen port: 0 local, 1 east, 2 west, 3 north, 4 south |

## Verification
Two things can happen in the same cycle: a new request is accepted while the previous selection drains, and a stall holds the previous selection in place. The bench drives `sel_ready` from a pseudo-random pattern while requests arrive back to back. This gives edges where the output both drains and refills, and edges where a request has to wait behind a frozen choice. A scoreboard receives the expected port when each request is accepted. Each drained selection is compared in order against it, and every stalled cycle is checked for an unchanged port and a low `req_ready`.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  localparam int BUSY_E = 0;
  localparam int BUSY_N = 1;
  localparam int BUSY_S = 2;
  localparam int BUSY_W = 3;

  typedef struct packed {
    logic go_local;
    logic go_east;
    logic go_west;
    logic go_north;
    logic go_south;
  } prod_t;
endpackage

// File: rtl/wf_offset_decode.sv
module wf_offset_decode #(
  parameter int OFF_W = 8
) (
  input  logic signed [OFF_W-1:0] dx,
  input  logic signed [OFF_W-1:0] dy,
  output wf_pkg::prod_t           prod
);
  localparam logic signed [OFF_W-1:0] ZERO = '0;

  always_comb begin
    prod.go_west  = dx < ZERO;
    prod.go_east  = dx > ZERO;
    prod.go_north = dy > ZERO;
    prod.go_south = dy < ZERO;
    prod.go_local = (dx == ZERO) && (dy == ZERO);
  end
endmodule

// File: rtl/wf_port_pick.sv
module wf_port_pick #(
  parameter int BUSY_W = wf_pkg::BUSY_W
) (
  input  wf_pkg::prod_t     prod,
  input  logic [BUSY_W-1:0] busy,
  output wf_pkg::port_e     port
);
  import wf_pkg::*;

  logic y_port_busy;
  port_e y_port;

  always_comb begin
    y_port      = prod.go_north ? PORT_NORTH : PORT_SOUTH;
    y_port_busy = prod.go_north ? busy[BUSY_N] : busy[BUSY_S];
    if (prod.go_west) begin
      port = PORT_WEST;
    end else if (prod.go_east && (prod.go_north || prod.go_south)) begin
      port = (busy[BUSY_E] && !y_port_busy) ? y_port : PORT_EAST;
    end else if (prod.go_east) begin
      port = PORT_EAST;
    end else if (prod.go_north || prod.go_south) begin
      port = y_port;
    end else begin
      port = PORT_LOCAL;
    end
  end
endmodule

// File: rtl/wf_hold_stage.sv
module wf_hold_stage #(
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/wf_route_sel.sv
module wf_route_sel #(
  parameter int OFF_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic signed [OFF_W-1:0] req_dx,
  input  logic signed [OFF_W-1:0] req_dy,
  input  logic [2:0]              link_busy,
  output logic                    sel_valid,
  input  logic                    sel_ready,
  output logic [2:0]              sel_port
);
  import wf_pkg::*;

  prod_t prod;
  port_e pick;

  wf_offset_decode #(.OFF_W(OFF_W)) u_dec (
    .dx(req_dx), .dy(req_dy), .prod(prod)
  );

  wf_port_pick #(.BUSY_W(BUSY_W)) u_pick (
    .prod(prod), .busy(link_busy), .port(pick)
  );

  wf_hold_stage #(.DATA_W(3)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pick),
    .out_valid(sel_valid), .out_ready(sel_ready), .out_data(sel_port)
  );
endmodule

// File: rtl/wf_route_sel_chk.sv
module wf_route_sel_chk #(
  parameter int OFF_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic signed [OFF_W-1:0] req_dx,
  input logic signed [OFF_W-1:0] req_dy,
  input logic                    sel_valid,
  input logic                    sel_ready,
  input logic [2:0]              sel_port
);
  localparam logic signed [OFF_W-1:0] ZERO = '0;
  logic take;
  assign take = req_valid && req_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !sel_valid); // R1
  AST_WEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_dx < ZERO) |=> sel_port == 3'd2); // R2
  AST_LOCAL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_dx == ZERO && req_dy == ZERO) |=> sel_port == 3'd0); // R4
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> sel_valid); // R7
  AST_HOLD_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ready) |=> (sel_valid && $stable(sel_port))); // R8
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ready) |-> !req_ready); // R8
  AST_NO_WEST_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_dx >= ZERO) |=> sel_port != 3'd2); // R9
endmodule

bind wf_route_sel wf_route_sel_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_dx(req_dx), .req_dy(req_dy), .sel_valid(sel_valid),
  .sel_ready(sel_ready), .sel_port(sel_port)
);

// File: tb/tb_wf_route_sel.sv
module tb_wf_route_sel;
  localparam int OFF_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic signed [OFF_W-1:0] req_dx = '0;
  logic signed [OFF_W-1:0] req_dy = '0;
  logic [2:0] link_busy = '0;
  logic sel_valid;
  logic sel_ready = 1'b1;
  logic [2:0] sel_port;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit random_ready = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [2:0] expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  wf_route_sel #(.OFF_W(OFF_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dx(req_dx), .req_dy(req_dy), .link_busy(link_busy),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_port(sel_port)
  );

  function automatic logic [2:0] model(int dx, int dy, logic [2:0] b);
    logic ybusy;
    ybusy = (dy > 0) ? b[1] : b[2];
    if (dx < 0) return 3'd2;                       // R2
    if (dx > 0 && dy != 0) begin
      if (b[0] && !ybusy) return (dy > 0) ? 3'd3 : 3'd4; // R5
      return 3'd1;                                 // R6 (or R5 east free)
    end
    if (dx > 0) return 3'd1;                       // R3
    if (dy > 0) return 3'd3;                       // R3
    if (dy < 0) return 3'd4;                       // R3
    return 3'd0;                                   // R4
  endfunction

  function automatic string req_of(int dx, int dy, logic [2:0] b);
    if (dx < 0) return "R2";
    if (dx == 0 && dy == 0) return "R4";
    if (dx > 0 && dy != 0) return (b[0] != ((dy > 0) ? b[1] : b[2])) ? "R5" : "R6";
    return "R3";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int dx, int dy, logic [2:0] b);
    @(negedge clk);
    req_valid = 1'b1;
    req_dx = OFF_W'(dx);
    req_dy = OFF_W'(dy);
    link_busy = b;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    expq.push_back(model(dx, dy, b));
    tagq.push_back(req_of(dx, dy, b));
    @(posedge clk);
    #2;
    check(sel_valid == 1'b1, "R7", int'(sel_valid), 1);
    req_valid = 1'b0;
  endtask

  // out_ready pattern, changed at negedge
  always @(negedge clk) begin
    if (random_ready) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sel_ready <= lfsr[0] | lfsr[2];
    end else begin
      sel_ready <= 1'b1;
    end
  end

  // scoreboard monitor: samples just before each rising edge
  logic       prev_stall = 1'b0;
  logic [2:0] prev_port = '0;
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (prev_stall) begin
        check(sel_valid && sel_port == prev_port, "R8", int'(sel_port), int'(prev_port));
      end
      if (sel_valid && !sel_ready) begin
        check(!req_ready, "R8", int'(req_ready), 0);
      end
      if (sel_valid && sel_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7", 1, 0);
        end else begin
          logic [2:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(sel_port == e, t, int'(sel_port), int'(e));
          if (e != 3'd2) check(sel_port != 3'd2, "R9", int'(sel_port), int'(e));
        end
      end
      prev_stall = sel_valid && !sel_ready;
      prev_port  = sel_port;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #12;
    check(sel_valid == 1'b0, "R1", int'(sel_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(sel_valid == 1'b0, "R1", int'(sel_valid), 0);
    @(negedge clk);
    check(sel_valid == 1'b0, "R1", int'(sel_valid), 0);

    // directed corners, always-ready output
    send(-1, 0, 3'b000);      // R2
    send(-5, 7, 3'b111);      // R2 all busy
    send(-128, -128, 3'b000); // R2 extreme
    send(3, 0, 3'b001);       // R3 east even if busy
    send(0, 4, 3'b010);       // R3 north
    send(0, -2, 3'b100);      // R3 south
    send(0, 0, 3'b111);       // R4
    send(2, 3, 3'b001);       // R5 north chosen
    send(2, -3, 3'b001);      // R5 south chosen
    send(2, 3, 3'b010);       // R5 east chosen
    send(127, 127, 3'b000);   // R6 both free
    send(1, -1, 3'b101);      // R6 both busy
    send(0, 0, 3'b000);       // R4

    // sweep with random back-pressure
    random_ready = 1'b1;
    foreach (expq[i]) begin end
    for (int a = 0; a < 4; a++) begin
      for (int c = 0; c < 3; c++) begin
        for (int b = 0; b < 8; b++) begin
          int dxv;
          int dyv;
          dxv = (a == 0) ? -3 : (a == 1) ? 0 : (a == 2) ? 2 : 127;
          dyv = (c == 0) ? -1 : (c == 1) ? 0 : 5;
          send(dxv, dyv, 3'(b));
        end
      end
    end

    random_ready = 1'b0;
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R7", expq.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule